// File: doc/BRIEF.md
# Wiper Nonvolatile Store and Restore Sequencer

This block owns an 8-bit wiper setting and the nonvolatile copy behind it. The nonvolatile copy is modelled inside the block as a storage word. That word keeps its content across a reset of the block and holds midscale (0x80) before anything has ever been written to it. Reset forces the wiper to midscale. When reset is released, a power-on restore runs and loads the wiper from the stored word.

A command decoder drives the block through a single command strobe with a 2-bit operation code and an 8-bit data byte. The four operations are:

- a direct wiper write;
- a direct write of the stored word;
- a store, which copies the wiper into the stored word;
- a restore, which copies the stored word into the wiper.

Every duration is a parameter counted in clock cycles: the power-on restore, the command restore, the nonvolatile write, and the rewrite lockout that follows reset. The defaults suit a 50 MHz clock. A bench uses short values.

The command interface has no back-pressure. A strobed command is taken or dropped in the cycle it is presented. A dropped command changes nothing except that it sets a sticky error flag, which only reset clears. `busy` tells the decoder when a nonvolatile operation is in flight. `nv_locked` tells it when writes to the stored word are still blocked after reset.

Top module: `nv_wiper_seq`

## Requirements
- R1: While reset is low, `wiper` is 0x80, `busy` is 1 and `err` is 0.
- R2: Before any write, the stored word reads 0x80. After reset is released, `busy` stays high for BOOT_CYC+1 cycles. `wiper` takes the stored value one cycle before `busy` falls.
- R3: A wiper write (op code 0) that is not dropped sets `wiper` to `cmd_data` at the next clock edge.
- R4: A stored-word write (op code 1) accepted while idle and unlocked raises `busy` for STORE_CYC cycles. `nv_word` changes only at the edge where `busy` falls, and then takes the byte given with the command.
- R5: A store (op code 2) accepted while idle and unlocked raises `busy` for STORE_CYC cycles. It commits the `wiper` value from the cycle of acceptance, even if the wiper is rewritten meanwhile.
- R6: A restore (op code 3) accepted while idle raises `busy` for RESTORE_CYC+1 cycles. `wiper` equals the stored word one cycle before `busy` falls.
- R7: Op codes 1, 2 or 3 presented while `busy` is high are dropped and set `err`.
- R8: A wiper write during a restore, including the power-on restore, is dropped and sets `err`. A wiper write during a store or stored-word write is applied.
- R9: `nv_locked` is high for REWRITE_CYC cycles after reset release and then stays low. Op codes 1 and 2 presented while it is high are dropped and set `err`. A restore is not blocked by it.
- R10: `err` stays set until reset, which clears it.
- R11: The stored word is not cleared by reset, so the power-on restore after a reset brings back the last committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 wiper write, 1 stored-word write, 2 store, 3 restore |
| cmd_data | input | 8 | Data byte for op codes 0 and 1 |
| wiper | output | 8 | Current wiper setting |
| nv_word | output | 8 | Current content of the stored word |
| busy | output | 1 | Nonvolatile operation or restore in progress |
| nv_locked | output | 1 | Post-reset rewrite lockout active |
| err | output | 1 | Sticky flag: a command was dropped |

## Verification
Directed sequences place each operation in each phase: during the power-on restore, inside the lockout, while idle, and while another operation is running. This separates the accept and drop rules for every op code in every phase. A store followed by a wiper rewrite shows whether the committed byte is the snapshot taken at acceptance or the live wiper. A reset after a committed write shows that the stored word survives reset. Random command streams with about one strobe in three are compared cycle by cycle against a behavioural model. These streams exercise back-to-back and overlapping requests and commands that land on the edge where an operation finishes.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [1:0] {
    OP_WIPER   = 2'd0,
    OP_NVWR    = 2'd1,
    OP_STORE   = 2'd2,
    OP_RESTORE = 2'd3
  } nv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_FETCH,
    ST_SETTLE
  } seq_state_e;

  function automatic int max_of3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/nv_down_timer.sv
module nv_down_timer #(
  parameter int CNT_W     = 8,
  parameter int RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RESET_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nv_cell.sv
module nv_cell #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  // Retained content: deliberately outside the block reset.
  logic [DATA_W-1:0] cell_q = INIT;

  always_ff @(posedge clk) begin
    if (we) cell_q <= wdata;
  end

  assign rdata = cell_q;
endmodule

// File: rtl/nv_wiper_seq.sv
module nv_wiper_seq
  import nv_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BOOT_CYC    = 15000,
  parameter int RESTORE_CYC = 15000,
  parameter int STORE_CYC   = 1300000,
  parameter int REWRITE_CYC = 27000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] wiper,
  output logic [DATA_W-1:0] nv_word,
  output logic              busy,
  output logic              nv_locked,
  output logic              err
);
  localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);
  localparam int MAX_CYC = max_of3(BOOT_CYC, RESTORE_CYC, STORE_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int LOCK_W  = $clog2(REWRITE_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] wiper_q, snap_q;
  logic              err_q;
  logic              op_zero, lock_zero;
  logic              idle, acc_wiper, acc_nv, acc_rest, drop;
  logic              nv_we, fetch_done;
  logic [CNT_W-1:0]  op_len;
  nv_op_e            op;

  assign op   = nv_op_e'(cmd_op);
  assign idle = (state_q == ST_IDLE);

  // Command acceptance rules.
  assign acc_wiper = cmd_valid && op == OP_WIPER &&
                     (state_q == ST_IDLE || state_q == ST_PROG);
  assign acc_nv    = cmd_valid && (op == OP_NVWR || op == OP_STORE) &&
                     idle && lock_zero;
  assign acc_rest  = cmd_valid && op == OP_RESTORE && idle;
  assign drop      = cmd_valid && !(acc_wiper || acc_nv || acc_rest);

  assign op_len     = acc_nv ? CNT_W'(STORE_CYC - 1) : CNT_W'(RESTORE_CYC - 1);
  assign nv_we      = (state_q == ST_PROG) && op_zero;
  assign fetch_done = (state_q == ST_FETCH) && op_zero;

  nv_down_timer #(
    .CNT_W    (CNT_W),
    .RESET_VAL(BOOT_CYC - 1)
  ) i_op_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (acc_nv || acc_rest),
    .load_val(op_len),
    .en      (state_q == ST_PROG || state_q == ST_FETCH),
    .zero    (op_zero)
  );

  nv_down_timer #(
    .CNT_W    (LOCK_W),
    .RESET_VAL(REWRITE_CYC)
  ) i_lock_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (1'b0),
    .load_val('0),
    .en      (1'b1),
    .zero    (lock_zero)
  );

  nv_cell #(
    .DATA_W(DATA_W),
    .INIT  (MIDSCALE)
  ) i_cell (
    .clk  (clk),
    .we   (nv_we),
    .wdata(snap_q),
    .rdata(nv_word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (acc_nv) state_d = ST_PROG;
                 else if (acc_rest) state_d = ST_FETCH;
      ST_PROG:   if (op_zero) state_d = ST_IDLE;
      ST_FETCH:  if (op_zero) state_d = ST_SETTLE;
      ST_SETTLE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      wiper_q <= MIDSCALE;
      snap_q  <= MIDSCALE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (fetch_done)     wiper_q <= nv_word;
      else if (acc_wiper) wiper_q <= cmd_data;
      if (acc_nv)         snap_q  <= (op == OP_STORE) ? wiper_q : cmd_data;
      if (drop)           err_q   <= 1'b1;
    end
  end

  assign wiper     = wiper_q;
  assign busy      = !idle;
  assign nv_locked = !lock_zero;
  assign err       = err_q;
endmodule

// File: rtl/nv_wiper_seq_chk.sv
module nv_wiper_seq_chk
  import nv_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [DATA_W-1:0] cmd_data,
  input logic [DATA_W-1:0] wiper,
  input logic [DATA_W-1:0] nv_word,
  input logic              busy,
  input logic              nv_locked,
  input logic              err
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10

  AST_NV_CHANGE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv_word) |-> $fell(busy)); // R4

  AST_WIPER_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WIPER && !busy) |=> wiper == $past(cmd_data)); // R3

  AST_STORE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STORE && !busy && !nv_locked) |=> busy); // R5

  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && cmd_op != OP_WIPER) |=> err); // R7

  AST_LOCK_NEVER_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_locked |=> !nv_locked); // R9

  AST_LOCK_DROPS_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && nv_locked && (cmd_op == OP_NVWR || cmd_op == OP_STORE)) |=> err); // R9
endmodule

bind nv_wiper_seq nv_wiper_seq_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_nv_wiper_seq.sv
module test_nv_wiper_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BOOT = 6, RST = 5, STO = 9, RW = 20;

  logic       clk = 0, rst_n = 0;
  logic       cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_data = 0;
  logic [7:0] wiper, nv_word;
  logic       busy, nv_locked, err;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_wiper_seq #(.DATA_W(8), .BOOT_CYC(BOOT), .RESTORE_CYC(RST),
                 .STORE_CYC(STO), .REWRITE_CYC(RW)) i_nv_wiper_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .wiper(wiper), .nv_word(nv_word), .busy(busy),
    .nv_locked(nv_locked), .err(err));

  // Behavioural model built from the requirements.
  int m_kind, m_rem, m_lock, k0;
  logic [7:0] m_wiper, m_snap, m_nv = 8'h80;
  bit m_err, was_busy, locked;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 2; m_rem = BOOT + 1; m_wiper = 8'h80; m_err = 0; m_lock = RW;
    end else begin
      k0 = m_kind; was_busy = (m_kind != 0); locked = (m_lock != 0);
      if (m_lock > 0) m_lock--;
      if (was_busy) begin
        m_rem--;
        if (m_kind == 2 && m_rem == 1) m_wiper = m_nv;
        if (m_rem == 0) begin
          if (m_kind == 1) m_nv = m_snap;
          m_kind = 0;
        end
      end
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: if (k0 == 2) m_err = 1; else m_wiper = cmd_data;
          2'd1, 2'd2: if (was_busy || locked) m_err = 1;
                      else begin
                        m_kind = 1; m_rem = STO;
                        m_snap = (cmd_op == 2'd2) ? m_wiper : cmd_data;
                      end
          default: if (was_busy) m_err = 1;
                   else begin m_kind = 2; m_rem = RST + 1; end
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 wiper vs model", wiper, m_wiper);
    chk("R4 nv_word vs model", nv_word, m_nv);
    chk("R7 busy vs model", busy, m_kind != 0);
    chk("R10 err vs model", err, m_err);
    chk("R9 nv_locked vs model", nv_locked, m_lock != 0);
  end

  task automatic op(input int code, input logic [7:0] d);
    cmd_valid = 1; cmd_op = 2'(code); cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 wiper in reset", wiper, 8'h80);
    chk("R1 busy in reset", busy, 1);
    chk("R1 err in reset", err, 0);
    rst_n = 1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] pick_data();
    return 8'($urandom_range(0, 255));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20250));
    @(negedge clk);
    do_reset();
    chk("R2 stored word initial", nv_word, 8'h80);
    wait_idle(n);
    chk("R2 boot busy length", n, BOOT + 1);
    chk("R2 boot wiper", wiper, 8'h80);
    op(0, 8'h55);
    chk("R3 wiper write", wiper, 8'h55);
    chk("R3 no error", err, 0);
    op(2, 8'h00);
    chk("R9 locked store not started", busy, 0);
    chk("R9 locked store err", err, 1);
    chk("R9 stored word untouched", nv_word, 8'h80);
    op(3, 8'h00);
    chk("R9 restore allowed while locked", busy, 1);
    op(0, 8'hEE);
    wait_idle(n);
    chk("R6 restore busy length", n + 1, RST + 1);
    chk("R6 restored wiper", wiper, 8'h80);
    chk("R10 err still set", err, 1);
    do_reset();
    @(negedge clk);
    chk("R10 err cleared by reset", err, 0);
    repeat (RW + 2) @(negedge clk);
    chk("R9 lock ended", nv_locked, 0);
    op(1, 8'h3C);
    chk("R4 nv write busy", busy, 1);
    op(0, 8'hA1);
    chk("R8 wiper write during nv write", wiper, 8'hA1);
    op(3, 8'h00);
    chk("R7 restore while busy err", err, 1);
    wait_idle(n);
    chk("R4 stored word written", nv_word, 8'h3C);
    op(2, 8'h00);
    op(0, 8'h12);
    wait_idle(n);
    chk("R5 store snapshot", nv_word, 8'hA1);
    chk("R5 wiper kept live value", wiper, 8'h12);
    op(3, 8'h00);
    op(0, 8'h77);
    chk("R8 wiper write dropped in restore", wiper, 8'h12);
    wait_idle(n);
    chk("R6 restore result", wiper, 8'hA1);
    do_reset();
    wait_idle(n);
    chk("R11 stored word survives reset", wiper, 8'hA1);
    chk("R11 err clear", err, 0);
    // Random phase, checked by the model comparison.
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        cmd_valid = 1; cmd_op = 2'($urandom_range(0, 3)); cmd_data = pick_data();
      end else cmd_valid = 0;
      @(negedge clk);
    end
    cmd_valid = 0;
    wait_idle(n);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule